// File: doc/BRIEF.md
# Receive FIFO with Polled Status Flags

This block sits between a serial receiver and a CPU. Each byte the receiver produces arrives with a framing-error flag and a parity-error flag. The block queues them in a 16-entry first-in first-out store. The CPU reads the oldest byte through a data port. It polls a set of status bits: error flags for the byte now at the head, a threshold-reached flag, a sticky overrun flag and the current fill count.

A 2-bit select picks how many stored bytes count as enough to service. Once the fill count reaches that number, the threshold-reached flag rises. It can also drive an interrupt request, gated by an enable input. Software clears the flag with a handshake: it reads the status while the flag is 1, then writes 0 to the flag bit. The clear takes effect only if the queue has by then been drained below the threshold. A standby input clears the status flags while leaving the stored bytes in place.

Top module: `rxq_status`

## Requirements
- R1: The store holds up to 16 entries and returns them in arrival order. `head_data` shows the oldest byte, and `fill_count` shows the number of stored entries. Both update in the cycle after the accepted push or pop.
- R2: `head_ferr` and `head_perr` equal the error flags stored with the head entry, and are 0 when the store is empty.
- R3: A push while 16 entries are stored and no pop is requested is dropped. `fill_count` stays 16 and `overrun` becomes 1 after that clock edge.
- R4: `overrun` stays 1 until a status write with `wr_ovr_bit` = 0. A status write with `wr_ovr_bit` = 1 leaves it unchanged.
- R5: A pop on an empty store moves no pointer. `head_data` reads 0 and `fill_count` stays 0, and the next pushed byte appears at the head.
- R6: `trig_sel` values 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 entries. `data_full` is 1 one clock after `fill_count` is at or above the selected threshold.
- R7: `data_full` clears only on a status write with `wr_full_bit` = 0, and only when both of these hold: a status read saw the flag at 1 after the previous status write, and `fill_count` is below the threshold. No other write and no drain of the store clears it.
- R8: `irq` equals `data_full` AND `rx_ie`.
- R9: A push and a pop in the same cycle on a non-empty store leave `fill_count` unchanged, even at 16 entries. No overrun is flagged, and the order of the entries is kept.
- R10: While `standby` is 1, `head_ferr` and `head_perr` read 0. After the next edge, `data_full` and `overrun` are 0. Stored entries and `fill_count` are kept.
- R11: After reset, `fill_count`, `head_data`, the error flags, `data_full`, `overrun` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Low-power state; clears status flags |
| push_valid | input | 1 | Receiver offers a byte this cycle |
| push_data | input | 8 | Received byte |
| push_ferr | input | 1 | Framing error for the offered byte |
| push_perr | input | 1 | Parity error for the offered byte |
| pop | input | 1 | CPU read strobe on the data port |
| stat_rd | input | 1 | CPU status read strobe |
| stat_wr | input | 1 | CPU status write strobe |
| wr_full_bit | input | 1 | Value written to the threshold flag |
| wr_ovr_bit | input | 1 | Value written to the overrun flag |
| trig_sel | input | 2 | Threshold select |
| rx_ie | input | 1 | Receive interrupt enable |
| head_data | output | 8 | Byte at the head, 0 when empty |
| head_ferr | output | 1 | Framing error of the head byte |
| head_perr | output | 1 | Parity error of the head byte |
| fill_count | output | 5 | Number of stored entries |
| data_full | output | 1 | Threshold-reached flag |
| overrun | output | 1 | Sticky dropped-push flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the store to capacity under every threshold select. It checks the count after each push and the threshold flag after each push, so a design that compared with the wrong threshold or flagged one entry early would be caught at the exact step. It then tries each wrong way to clear the flag: a write without a prior read, a write while still above the threshold, and a full drain with no write. A design that cleared the flag on any write or as the count fell would drop it where it must stay set. It also pushes into a full store, with and without a simultaneous pop, and pops an empty one. This exposes designs that accept a seventeenth byte, miss the overrun, flag overrun when a pop made room, or move the read pointer past empty, which would show up as wrong bytes at the head.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg
// Shared types for the receive queue. An entry bundles one received byte
// with the two line-error flags that the receiver reported for it.
package rxq_pkg;

    localparam int unsigned RXQ_DW = 8;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [RXQ_DW-1:0] data;
    } rxq_entry_t;

endpackage

// File: rtl/rxq_store.sv
// Module rxq_store
// Circular entry store with read and write pointers and a fill counter.
// Assumes wr_en and rd_en are already qualified by the caller: wr_en is never
// raised when full without rd_en, and rd_en is never raised when empty.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  rxq_entry_t       wr_entry,
    input  logic             rd_en,
    output rxq_entry_t       head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rxq_entry_t       slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Next position of a pointer, wrapping at the last slot.
    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    // One register per slot, loaded when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_ptr == PTR_W'(g))) begin
                slot[g] <= wr_entry;
            end
        end
    end

    // Advance the write pointer on each accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            wr_ptr <= ptr_inc(wr_ptr);
        end
    end

    // Advance the read pointer on each accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rd_en) begin
            rd_ptr <= ptr_inc(rd_ptr);
        end
    end

    // Track occupancy; a push and pop together cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // Expose the head slot and occupancy conditions.
    always_comb begin
        head  = slot[rd_ptr];
        empty = (count == '0);
        full  = (count == FULL_CNT);
    end

endmodule

// File: rtl/rxq_admit.sv
// Module rxq_admit
// Decides which requested pushes and pops take effect this cycle.
// Assumes full and empty describe the store before this cycle's edge.
// A pop on an empty store is ignored. A push on a full store is accepted
// only if a real pop frees a slot in the same cycle; otherwise it is lost.
module rxq_admit (
    input  logic push_req,
    input  logic pop_req,
    input  logic full,
    input  logic empty,
    output logic push_ok,
    output logic pop_ok,
    output logic push_lost
);

    // Qualify requests against occupancy.
    always_comb begin
        pop_ok    = pop_req && !empty;
        push_ok   = push_req && (!full || pop_ok);
        push_lost = push_req && !push_ok;
    end

endmodule

// File: rtl/rxq_full_flag.sv
// Module rxq_full_flag
// Threshold-reached flag with a read-then-write-zero clear handshake.
// The flag is set whenever count is at or above level. A status read that
// sees the flag at 1 arms the clear; any status write disarms it. A write of
// 0 clears the flag only while armed and with count below level.
// Standby clears both flag and arm.
module rxq_full_flag #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic             stat_rd,
    input  logic             stat_wr,
    input  logic             wr_bit,
    output logic             flag
);

    logic armed;
    logic reached;
    logic clr_ok;

    // Compare occupancy with the threshold and qualify the clear.
    always_comb begin
        reached = (count >= level);
        clr_ok  = stat_wr && !wr_bit && armed && !reached;
    end

    // Hold the flag: set by level, cleared by the handshake or standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (standby) begin
            flag <= 1'b0;
        end else if (reached) begin
            flag <= 1'b1;
        end else if (clr_ok) begin
            flag <= 1'b0;
        end
    end

    // Remember that software has observed the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (standby || stat_wr) begin
            armed <= 1'b0;
        end else if (stat_rd && flag) begin
            armed <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_status.sv
// Module rxq_status
// Receive queue with polled status. Joins admission control, the entry
// store, the threshold flag and a sticky overrun bit. Head outputs read
// zero when the store is empty; head error flags are masked in standby.
// Assumes all strobes are synchronous to clk and one cycle wide per access.
module rxq_status
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned TRIG_0 = 1,
    parameter int unsigned TRIG_1 = 4,
    parameter int unsigned TRIG_2 = 8,
    parameter int unsigned TRIG_3 = 14,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              push_valid,
    input  logic [RXQ_DW-1:0] push_data,
    input  logic              push_ferr,
    input  logic              push_perr,
    input  logic              pop,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              wr_full_bit,
    input  logic              wr_ovr_bit,
    input  logic [1:0]        trig_sel,
    input  logic              rx_ie,
    output logic [RXQ_DW-1:0] head_data,
    output logic              head_ferr,
    output logic              head_perr,
    output logic [CNT_W-1:0]  fill_count,
    output logic              data_full,
    output logic              overrun,
    output logic              irq
);

    rxq_entry_t       in_entry;
    rxq_entry_t       head;
    logic             empty;
    logic             full;
    logic             push_ok;
    logic             pop_ok;
    logic             push_lost;
    logic [CNT_W-1:0] level;

    // Pack the receiver's byte and flags into one entry.
    always_comb begin
        in_entry.data = push_data;
        in_entry.ferr = push_ferr;
        in_entry.perr = push_perr;
    end

    // Map the 2-bit select onto a threshold count.
    always_comb begin
        unique case (trig_sel)
            2'd0:    level = CNT_W'(TRIG_0);
            2'd1:    level = CNT_W'(TRIG_1);
            2'd2:    level = CNT_W'(TRIG_2);
            default: level = CNT_W'(TRIG_3);
        endcase
    end

    rxq_admit u_admit (
        .push_req  (push_valid),
        .pop_req   (pop),
        .full      (full),
        .empty     (empty),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .push_lost (push_lost)
    );

    rxq_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push_ok),
        .wr_entry (in_entry),
        .rd_en    (pop_ok),
        .head     (head),
        .count    (fill_count),
        .empty    (empty),
        .full     (full)
    );

    rxq_full_flag #(
        .CNT_W (CNT_W)
    ) u_full_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .count   (fill_count),
        .level   (level),
        .stat_rd (stat_rd),
        .stat_wr (stat_wr),
        .wr_bit  (wr_full_bit),
        .flag    (data_full)
    );

    // Sticky overrun: set by a lost push, cleared by writing 0 or standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (standby) begin
            overrun <= 1'b0;
        end else if (push_lost) begin
            overrun <= 1'b1;
        end else if (stat_wr && !wr_ovr_bit) begin
            overrun <= 1'b0;
        end
    end

    // Present the head entry with empty and standby masking.
    always_comb begin
        head_data = empty ? '0 : head.data;
        head_ferr = !empty && !standby && head.ferr;
        head_perr = !empty && !standby && head.perr;
        irq       = data_full && rx_ie;
    end

endmodule

// File: rtl/rxq_status_checks.sv
// Module rxq_status_checks
// Port-level properties of rxq_status, attached with bind below.
// Thresholds are restated here from the requirement, not taken from the design.
module rxq_status_checks #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             standby,
    input logic             push_valid,
    input logic             pop,
    input logic             stat_wr,
    input logic [1:0]       trig_sel,
    input logic             rx_ie,
    input logic [7:0]       head_data,
    input logic             head_ferr,
    input logic             head_perr,
    input logic [CNT_W-1:0] fill_count,
    input logic             data_full,
    input logic             overrun,
    input logic             irq
);

    logic [CNT_W-1:0] thr;

    // Threshold per select value as the requirement states it.
    always_comb begin
        case (trig_sel)
            2'd0:    thr = CNT_W'(1);
            2'd1:    thr = CNT_W'(4);
            2'd2:    thr = CNT_W'(8);
            default: thr = CNT_W'(14);
        endcase
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    p_empty_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> (head_data == '0 && !head_ferr && !head_perr));

    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CNT_W'(DEPTH) && push_valid && !pop && !standby)
        |=> (fill_count == CNT_W'(DEPTH) && overrun));

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0 && pop && !push_valid) |=> (fill_count == '0));

    p_level_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count >= thr && !standby) |=> data_full);

    p_clear_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_full) |-> ($past(stat_wr) || $past(standby)));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (data_full && rx_ie));

    p_pushpop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop && fill_count != '0) |=> $stable(fill_count));

    p_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!data_full && !overrun));

endmodule

bind rxq_status rxq_status_checks #(.DEPTH(DEPTH)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby),
    .push_valid (push_valid),
    .pop        (pop),
    .stat_wr    (stat_wr),
    .trig_sel   (trig_sel),
    .rx_ie      (rx_ie),
    .head_data  (head_data),
    .head_ferr  (head_ferr),
    .head_perr  (head_perr),
    .fill_count (fill_count),
    .data_full  (data_full),
    .overrun    (overrun),
    .irq        (irq)
);

// File: tb/rxq_status_bench.sv
// Bench for rxq_status: sweeps every threshold select, fills and drains the
// store, and checks results against a queue model kept in the bench.
module rxq_status_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       push_ferr = 1'b0;
    logic       push_perr = 1'b0;
    logic       pop = 1'b0;
    logic       stat_rd = 1'b0;
    logic       stat_wr = 1'b0;
    logic       wr_full_bit = 1'b1;
    logic       wr_ovr_bit = 1'b1;
    logic [1:0] trig_sel = '0;
    logic       rx_ie = 1'b0;
    logic [7:0] head_data;
    logic       head_ferr;
    logic       head_perr;
    logic [4:0] fill_count;
    logic       data_full;
    logic       overrun;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [9:0] model[$];

    always #10 clk = ~clk;

    rxq_status u_rxq_status (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .push_valid(push_valid), .push_data(push_data),
        .push_ferr(push_ferr), .push_perr(push_perr), .pop(pop),
        .stat_rd(stat_rd), .stat_wr(stat_wr),
        .wr_full_bit(wr_full_bit), .wr_ovr_bit(wr_ovr_bit),
        .trig_sel(trig_sel), .rx_ie(rx_ie),
        .head_data(head_data), .head_ferr(head_ferr), .head_perr(head_perr),
        .fill_count(fill_count), .data_full(data_full),
        .overrun(overrun), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock with the given push/pop request; the model follows.
    task automatic cyc(input logic pv, input logic [7:0] d, input logic f,
                       input logic p, input logic po);
        int sz;
        bit acc;
        push_valid = pv; push_data = d; push_ferr = f; push_perr = p; pop = po;
        @(posedge clk); #2;
        push_valid = 1'b0; pop = 1'b0;
        sz  = model.size();
        acc = pv && (sz < 16 || (po && sz > 0));
        if (po && sz > 0) void'(model.pop_front());
        if (acc) model.push_back({f, p, d});
    endtask

    task automatic st_read();
        stat_rd = 1'b1; @(posedge clk); #2; stat_rd = 1'b0;
    endtask

    task automatic st_write(input logic fb, input logic ob);
        stat_wr = 1'b1; wr_full_bit = fb; wr_ovr_bit = ob;
        @(posedge clk); #2;
        stat_wr = 1'b0; wr_full_bit = 1'b1; wr_ovr_bit = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; @(posedge clk); @(posedge clk); #2; rst_n = 1'b1;
        model.delete();
    endtask

    task automatic chk_head(input string req);
        logic [9:0] e;
        e = (model.size() > 0) ? model[0] : 10'd0;
        chk(head_data == e[7:0], req, head_data, e[7:0]);
        chk(head_ferr == e[9], req, head_ferr, e[9]);
        chk(head_perr == e[8], req, head_perr, e[8]);
        chk(fill_count == model.size(), req, fill_count, model.size());
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11: reset state
        chk(fill_count == 0 && head_data == 0 && !head_ferr && !head_perr,
            "R11 reset outputs", fill_count, 0);
        chk(!data_full && !overrun && !irq, "R11 reset flags", data_full, 0);

        for (int t = 0; t < 4; t++) begin
            int thr;
            thr = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
            do_reset();
            trig_sel = 2'(t);
            rx_ie = t[0];
            for (int i = 1; i <= 16; i++) begin
                cyc(1'b1, 8'((t * 16 + i) ^ 8'h5A), i[0], i[1], 1'b0);
                chk(fill_count == i, "R1 count after push", fill_count, i);
                cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
                chk(data_full == (i >= thr), "R6 threshold flag", data_full, i >= thr);
                chk(irq == (data_full && rx_ie), "R8 irq gate", irq, data_full && rx_ie);
            end
            // R3: push into a full store is lost
            cyc(1'b1, 8'hEE, 1'b1, 1'b1, 1'b0);
            chk(fill_count == 16, "R3 count stays full", fill_count, 16);
            chk(overrun == 1'b1, "R3 overrun set", overrun, 1);
            // R7: write 0 without prior read does nothing
            st_write(1'b0, 1'b1);
            chk(data_full, "R7 write without read", data_full, 1);
            // R7: read then write 0 while at/above threshold does nothing
            st_read();
            st_write(1'b0, 1'b1);
            chk(data_full, "R7 write above threshold", data_full, 1);
            // R4: overrun clear only by writing 0
            st_write(1'b1, 1'b1);
            chk(overrun, "R4 write 1 keeps overrun", overrun, 1);
            st_write(1'b1, 1'b0);
            chk(!overrun, "R4 write 0 clears overrun", overrun, 0);
            // R1/R2: drain in order
            while (model.size() > 0) begin
                chk_head("R1 R2 head order and flags");
                cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
            end
            chk(data_full, "R7 drain does not clear", data_full, 1);
            st_write(1'b0, 1'b1);
            chk(data_full, "R7 unarmed write below threshold", data_full, 1);
            st_read();
            st_write(1'b0, 1'b1);
            chk(!data_full, "R7 armed write below threshold clears", data_full, 0);
            // R5: pop on empty
            cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
            chk(head_data == 0 && fill_count == 0, "R5 empty pop", fill_count, 0);
            cyc(1'b1, 8'hC3, 1'b0, 1'b1, 1'b0);
            chk_head("R5 push after empty pop");
            chk(head_data == 8'hC3, "R5 head after empty pop", head_data, 8'hC3);
        end

        // R9: push and pop together, partly filled and full
        do_reset();
        trig_sel = 2'd3;
        for (int i = 0; i < 3; i++) cyc(1'b1, 8'(8'h10 + i), 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 8'h20, 1'b1, 1'b0, 1'b1);
        chk(fill_count == 3, "R9 count kept mid", fill_count, 3);
        for (int i = 0; i < 13; i++) cyc(1'b1, 8'(8'h30 + i), 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 8'h77, 1'b1, 1'b1, 1'b1);
        chk(fill_count == 16, "R9 count kept full", fill_count, 16);
        chk(!overrun, "R9 no overrun when pop frees slot", overrun, 0);
        while (model.size() > 0) begin
            chk_head("R9 order after push and pop");
            cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        end

        // R10: standby clears status, keeps contents
        do_reset();
        trig_sel = 2'd0;
        for (int i = 0; i < 17; i++) cyc(1'b1, 8'(8'h80 + i), 1'b1, 1'b1, 1'b0);
        chk(data_full && overrun, "R10 flags set before standby", overrun, 1);
        standby = 1'b1; #2;
        chk(!head_ferr && !head_perr, "R10 head errors masked", head_ferr, 0);
        @(posedge clk); #2;
        chk(!data_full && !overrun, "R10 flags cleared", data_full, 0);
        chk(fill_count == 16, "R10 contents kept", fill_count, 16);
        standby = 1'b0; #2;
        chk_head("R10 head after standby");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule